// File: doc/BRIEF.md
# Converter Low-Power State Sequencer

This block decides whether a data converter runs normally, rests in a light low-power state (Nap) or a deep one (Sleep), and sequences the moves between them. The wanted state comes from a three-level configuration strap, or from a software-written mode field once the register path has taken over. While the converter is resting, or waking back up, the block holds its output-enable low. Sample data, the forwarded clock and the overflow flag are all gated by that enable, so they go high impedance.

Waking takes a fixed number of reference-clock cycles. Sleep needs far longer than Nap. The wait grows by a further relock period when the sample clock was seen to stop during the rest. Only after the whole wait has elapsed does the block raise output-enable and ready together. A fresh rest request that arrives during the wait sends the block back to rest, and the next wake starts its count from the beginning.

Top module: `pwr_mgr`

## Requirements
- R1: While reset is high and on the first cycle after it, `out_en` and `ready` are 0 and `pwr_state` reads 2'b11 (waking). With a Normal request held, `out_en` rises exactly NAP_CYC clock edges after the last reset edge.
- R2: Strap decode on `strap_lvl` ({float sensed, pin high}): 2'b01 requests Normal, 2'b00 requests Sleep, and 2'b10 or 2'b11 request Nap.
- R3: While register control is active, `ovr_mode` alone sets the request and the strap is ignored: 2'b00 Normal, 2'b01 Nap, 2'b10 Sleep, 2'b11 Normal.
- R4: Register control starts on the first cycle `ovr_en` is high and stays active after `ovr_en` falls. Only reset returns control to the strap.
- R5: `pwr_state` encodes 2'b00 Normal, 2'b01 Nap, 2'b10 Sleep, 2'b11 waking. A rest request from Normal takes effect at the next edge. `out_en` is 0 whenever `pwr_state` is not Normal.
- R6: After a Nap-only rest, `out_en` rises NAP_CYC+1 edges after a Normal request is first presented. One of those edges enters the waking state, and the other NAP_CYC make up the wait.
- R7: When Sleep was held at any point since Normal was left, the wake wait is SLP_CYC instead, including when the rest ended in Nap.
- R8: If `clk_act` is sampled low at an edge while resting, the wake wait grows by RELOCK_CYC. This flag is cleared when Normal is reached.
- R9: A rest request while waking returns the block to that rest state at the next edge with `out_en` still 0. The following wake runs a full fresh wait.
- R10: `ready` always equals `out_en`, and both are registered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst | input | 1 | Synchronous active-high reset |
| strap_lvl | input | 2 | Sensed strap: bit 1 floating, bit 0 pin high |
| ovr_en | input | 1 | Register-override enable (latches register control) |
| ovr_mode | input | 2 | Register power-mode field |
| clk_act | input | 1 | Sample-clock activity detector, 1 when edges seen |
| out_en | output | 1 | Enable for data, clock-out and overflow drivers |
| ready | output | 1 | Converter back in Normal after full recovery |
| pwr_state | output | 2 | Present state code |

## Verification
The bench builds the block with NAP_CYC=6, SLP_CYC=20 and RELOCK_CYC=9 in place of the microsecond-scale defaults. These small values let every wake wait be counted edge by edge, and they keep the three lengths distinct, so Nap-only, Sleep, Sleep-then-Nap and clock-stopped recoveries each give a different expected count. Because the counts stay short, a restart partway through a wait, the clearing of the relock flag on the next rest and the stickiness of register control across many cycles all fit in one run.

// File: rtl/pwr_pkg.sv
package pwr_pkg;

  typedef enum logic [1:0] {
    ST_RUN   = 2'b00,
    ST_NAP   = 2'b01,
    ST_SLEEP = 2'b10,
    ST_WAKE  = 2'b11
  } pstate_t;

  // Strap sense: bit 1 = floating, bit 0 = pin driven high.
  function automatic pstate_t strap_to_req(input logic [1:0] lvl);
    if (lvl[1])      return ST_NAP;
    else if (lvl[0]) return ST_RUN;
    else             return ST_SLEEP;
  endfunction

  // Register field: unused code maps to normal operation.
  function automatic pstate_t reg_to_req(input logic [1:0] code);
    case (code)
      2'b01:   return ST_NAP;
      2'b10:   return ST_SLEEP;
      default: return ST_RUN;
    endcase
  endfunction

endpackage

// File: rtl/pwr_req_sel.sv
module pwr_req_sel
  import pwr_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] strap_lvl,
  input  logic       ovr_en,
  input  logic [1:0] ovr_mode,
  output pstate_t    req_o
);

  logic reg_ctl_q;
  logic use_reg;

  // Once the register path is enabled it keeps control until reset.
  always_ff @(posedge clk) begin
    if (rst) reg_ctl_q <= 1'b0;
    else     reg_ctl_q <= reg_ctl_q | ovr_en;
  end

  assign use_reg = reg_ctl_q | ovr_en;

  always_comb begin
    if (use_reg) req_o = reg_to_req(ovr_mode);
    else         req_o = strap_to_req(strap_lvl);
  end

endmodule

// File: rtl/pwr_wake_timer.sv
module pwr_wake_timer #(
  parameter int unsigned CNT_W    = 8,
  parameter int unsigned INIT_VAL = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             done_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)               cnt_q <= CNT_W'(INIT_VAL);
    else if (load_i)       cnt_q <= load_val_i;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);

endmodule

// File: rtl/pwr_seq.sv
module pwr_seq
  import pwr_pkg::*;
#(
  parameter int unsigned NAP_CYC    = 4,
  parameter int unsigned SLP_CYC    = 16,
  parameter int unsigned RELOCK_CYC = 8,
  parameter int unsigned CNT_W      = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  pstate_t          req_i,
  input  logic             clk_act_i,
  input  logic             done_i,
  output logic             load_o,
  output logic [CNT_W-1:0] load_val_o,
  output pstate_t          state_o,
  output logic             out_en_o,
  output logic             ready_o
);

  localparam logic [CNT_W-1:0] NAP_LD = CNT_W'(NAP_CYC - 1);
  localparam logic [CNT_W-1:0] SLP_LD = CNT_W'(SLP_CYC - 1);
  localparam logic [CNT_W-1:0] RLK_LD = CNT_W'(RELOCK_CYC);

  pstate_t state_q, state_d;
  logic    stop_q, deep_q;
  logic    resting, stop_seen, deep_seen;

  assign resting   = (state_q == ST_NAP) || (state_q == ST_SLEEP);
  assign stop_seen = stop_q | (resting & ~clk_act_i);
  assign deep_seen = deep_q | (state_q == ST_SLEEP);

  always_comb begin
    state_d = state_q;
    load_o  = 1'b0;
    case (state_q)
      ST_RUN: begin
        if (req_i != ST_RUN) state_d = req_i;
      end
      ST_NAP, ST_SLEEP: begin
        if (req_i == ST_RUN) begin
          state_d = ST_WAKE;
          load_o  = 1'b1;
        end else begin
          state_d = req_i;
        end
      end
      default: begin
        if (req_i != ST_RUN) state_d = req_i;
        else if (done_i)     state_d = ST_RUN;
      end
    endcase
  end

  always_comb begin
    load_val_o = deep_seen ? SLP_LD : NAP_LD;
    if (stop_seen) load_val_o = load_val_o + RLK_LD;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_WAKE;
      stop_q   <= 1'b0;
      deep_q   <= 1'b0;
      out_en_o <= 1'b0;
      ready_o  <= 1'b0;
    end else begin
      state_q  <= state_d;
      stop_q   <= (state_d == ST_RUN) ? 1'b0 : stop_seen;
      deep_q   <= (state_d == ST_RUN) ? 1'b0 : deep_seen;
      out_en_o <= (state_d == ST_RUN);
      ready_o  <= (state_d == ST_RUN);
    end
  end

  assign state_o = state_q;

endmodule

// File: rtl/pwr_mgr.sv
module pwr_mgr #(
  parameter int unsigned NAP_CYC    = 250,
  parameter int unsigned SLP_CYC    = 250000,
  parameter int unsigned RELOCK_CYC = 13000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] strap_lvl,
  input  logic       ovr_en,
  input  logic [1:0] ovr_mode,
  input  logic       clk_act,
  output logic       out_en,
  output logic       ready,
  output logic [1:0] pwr_state
);

  import pwr_pkg::*;

  localparam int unsigned CNT_W = $clog2(SLP_CYC + RELOCK_CYC + 1);

  pstate_t          req;
  pstate_t          state;
  logic             tmr_load;
  logic             tmr_done;
  logic [CNT_W-1:0] tmr_val;

  pwr_req_sel u_sel (
    .clk       (clk),
    .rst       (rst),
    .strap_lvl (strap_lvl),
    .ovr_en    (ovr_en),
    .ovr_mode  (ovr_mode),
    .req_o     (req)
  );

  pwr_wake_timer #(
    .CNT_W    (CNT_W),
    .INIT_VAL (NAP_CYC - 1)
  ) u_tmr (
    .clk        (clk),
    .rst        (rst),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .done_o     (tmr_done)
  );

  pwr_seq #(
    .NAP_CYC    (NAP_CYC),
    .SLP_CYC    (SLP_CYC),
    .RELOCK_CYC (RELOCK_CYC),
    .CNT_W      (CNT_W)
  ) u_seq (
    .clk        (clk),
    .rst        (rst),
    .req_i      (req),
    .clk_act_i  (clk_act),
    .done_i     (tmr_done),
    .load_o     (tmr_load),
    .load_val_o (tmr_val),
    .state_o    (state),
    .out_en_o   (out_en),
    .ready_o    (ready)
  );

  assign pwr_state = state;

endmodule

// File: rtl/pwr_mgr_chk.sv
module pwr_mgr_chk #(
  parameter int unsigned NAP_CYC = 250
) (
  input logic       clk,
  input logic       rst,
  input logic [1:0] strap_lvl,
  input logic       ovr_en,
  input logic [1:0] ovr_mode,
  input logic       out_en,
  input logic       ready,
  input logic [1:0] pwr_state
);

  logic        ovr_seen;
  int unsigned wake_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      ovr_seen <= 1'b0;
      wake_cnt <= 0;
    end else begin
      ovr_seen <= ovr_seen | ovr_en;
      if (pwr_state == 2'b11) wake_cnt <= wake_cnt + 1;
      else                    wake_cnt <= 0;
    end
  end

  // R5: drivers disabled whenever not in normal operation
  a_r5_hiz_off_run: assert property (@(posedge clk) disable iff (rst)
    (pwr_state != 2'b00) |-> !out_en);

  // R10: ready tracks the enable
  a_r10_ready_match: assert property (@(posedge clk) disable iff (rst)
    ready == out_en);

  // R6: enable only returns after at least the short wake wait
  a_r6_min_wait: assert property (@(posedge clk) disable iff (rst)
    $rose(out_en) |-> (wake_cnt >= NAP_CYC));

  // R2: strap low requests sleep while the strap still has control
  a_r2_strap_sleep: assert property (@(posedge clk) disable iff (rst)
    (!ovr_seen && !ovr_en && strap_lvl == 2'b00) |=> (pwr_state == 2'b10));

  // R3: register nap code wins over any strap level
  a_r3_reg_nap: assert property (@(posedge clk) disable iff (rst)
    (ovr_en && ovr_mode == 2'b01) |=> (pwr_state == 2'b01));

  // R4: sticky register control, strap high cannot wake from register sleep
  a_r4_sticky_ctl: assert property (@(posedge clk) disable iff (rst)
    (ovr_seen && ovr_mode == 2'b10) |=> (pwr_state == 2'b10));

endmodule

bind pwr_mgr pwr_mgr_chk #(.NAP_CYC(NAP_CYC)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .strap_lvl (strap_lvl),
  .ovr_en    (ovr_en),
  .ovr_mode  (ovr_mode),
  .out_en    (out_en),
  .ready     (ready),
  .pwr_state (pwr_state)
);

// File: tb/pwr_mgr_tb.sv
`timescale 1ns/1ps
module pwr_mgr_tb;

  localparam int NAP = 6;
  localparam int SLP = 20;
  localparam int RLK = 9;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] strap_lvl = 2'b01;
  logic       ovr_en = 1'b0;
  logic [1:0] ovr_mode = 2'b00;
  logic       clk_act = 1'b1;
  logic       out_en, ready;
  logic [1:0] pwr_state;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  pwr_mgr #(.NAP_CYC(NAP), .SLP_CYC(SLP), .RELOCK_CYC(RLK)) u_dut (
    .clk(clk), .rst(rst), .strap_lvl(strap_lvl), .ovr_en(ovr_en),
    .ovr_mode(ovr_mode), .clk_act(clk_act), .out_en(out_en),
    .ready(ready), .pwr_state(pwr_state)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Edges until out_en is seen high.
  task automatic measure(output int n);
    n = 0;
    do begin
      tick();
      n++;
    end while (!out_en && n < 500);
  endtask

  task automatic t_reset();
    int n;
    rst = 1'b1; strap_lvl = 2'b01;
    repeat (3) tick();
    chk("R1 state in reset", pwr_state, 3);
    chk("R1 out_en in reset", out_en, 0);
    chk("R1 ready in reset", ready, 0);
    rst = 1'b0;
    measure(n);
    chk("R1 wake after reset", n, NAP);
    chk("R10 ready with out_en", ready, 1);
  endtask

  task automatic t_nap();
    int n;
    strap_lvl = 2'b10; tick();
    chk("R2 float selects nap", pwr_state, 1);
    chk("R5 out_en low in nap", out_en, 0);
    chk("R10 ready low in nap", ready, 0);
    strap_lvl = 2'b01;
    measure(n);
    chk("R6 nap recovery edges", n, NAP + 1);
  endtask

  task automatic t_strap11();
    int n;
    strap_lvl = 2'b11; tick();
    chk("R2 float+high selects nap", pwr_state, 1);
    strap_lvl = 2'b01;
    measure(n);
    chk("R6 nap recovery after 11", n, NAP + 1);
  endtask

  task automatic t_sleep();
    int n;
    strap_lvl = 2'b00; tick();
    chk("R2 low selects sleep", pwr_state, 2);
    chk("R5 out_en low in sleep", out_en, 0);
    strap_lvl = 2'b01;
    measure(n);
    chk("R7 sleep recovery edges", n, SLP + 1);
  endtask

  task automatic t_deep();
    int n;
    strap_lvl = 2'b00; repeat (3) tick();
    strap_lvl = 2'b10; tick();
    chk("R7 sleep to nap state", pwr_state, 1);
    strap_lvl = 2'b01;
    measure(n);
    chk("R7 sleep then nap uses long wait", n, SLP + 1);
  endtask

  task automatic t_clkstop();
    int n;
    strap_lvl = 2'b10; tick();
    clk_act = 1'b0; tick(); tick();
    clk_act = 1'b1; tick();
    strap_lvl = 2'b01;
    measure(n);
    chk("R8 relock extends nap wait", n, NAP + RLK + 1);
    strap_lvl = 2'b10; tick();
    strap_lvl = 2'b01;
    measure(n);
    chk("R8 flag cleared at normal", n, NAP + 1);
  endtask

  task automatic t_restart();
    int n;
    strap_lvl = 2'b10; tick();
    strap_lvl = 2'b01; tick();
    chk("R9 waking state", pwr_state, 3);
    chk("R5 out_en low while waking", out_en, 0);
    tick(); tick();
    strap_lvl = 2'b10; tick();
    chk("R9 back to nap", pwr_state, 1);
    chk("R9 out_en stays low", out_en, 0);
    strap_lvl = 2'b01;
    measure(n);
    chk("R9 full fresh wait", n, NAP + 1);
  endtask

  task automatic t_override();
    int n;
    ovr_mode = 2'b10; ovr_en = 1'b1; tick();
    chk("R3 register sleep", pwr_state, 2);
    ovr_en = 1'b0; repeat (4) tick();
    chk("R4 control stays with register", pwr_state, 2);
    chk("R4 out_en low", out_en, 0);
    ovr_mode = 2'b11;
    measure(n);
    chk("R3 code 11 is normal", n, SLP + 1);
    strap_lvl = 2'b00; ovr_mode = 2'b00; repeat (5) tick();
    chk("R3 strap ignored state", pwr_state, 0);
    chk("R3 strap ignored out_en", out_en, 1);
    ovr_mode = 2'b01; tick();
    chk("R3 register nap", pwr_state, 1);
    ovr_mode = 2'b00;
    measure(n);
    chk("R3 register nap recovery", n, NAP + 1);
  endtask

  task automatic t_reset_clears();
    int n;
    rst = 1'b1; strap_lvl = 2'b00; ovr_mode = 2'b00;
    tick(); tick();
    chk("R1 reset state again", pwr_state, 3);
    rst = 1'b0; tick();
    chk("R4 reset returns strap control", pwr_state, 2);
    strap_lvl = 2'b01;
    measure(n);
    chk("R7 sleep wait after reset", n, SLP + 1);
  endtask

  initial begin
    t_reset();
    t_nap();
    t_strap11();
    t_sleep();
    t_deep();
    t_clkstop();
    t_restart();
    t_override();
    t_reset_clears();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule